// File: doc/BRIEF.md
# Width-Limited In-Order Retirement Controller

This block decides, every cycle, which entries at the head of a reorder buffer leave it. It sees a window of the oldest `D` entries of the thread that the thread selector has picked. Each entry arrives with a ready bit and a set of status flags. The block walks the window from the oldest entry and retires entries in order. It stops at the first entry that cannot leave, or once `W` real instructions have retired.

Entries that were squashed drain out for free: they are removed without using any of the `W` credit. Instructions that serialise the machine (non-speculative operations, conditional stores, barriers) and faulting instructions are gated on two conditions. They must be the first real instruction of the cycle, and no stores may be waiting for writeback. When allowed, a serialising instruction produces a request to execute it, a faulting one produces a trap request, and an unexecuted load produces an uncached-replay request. Each such request stops the walk.

The block keeps the architectural PC and next-PC of the thread. It also holds a trap-pending state that blocks retirement until the trap handler reports back, and a count of cycles that used the full retirement width. The reorder buffer, the rename map and the trap handler are outside the block.

Top module: `retire_ctrl`

## Requirements
- R1: After reset, `pc_o` equals `RESET_PC`, `npc_o` equals `RESET_PC + 4`, `full_cnt_o` is 0 and `trap_pending_o` is 0.
- R2: Nothing retires while `sel_valid_i` is low or `trap_pending_o` is high. Within a cycle the walk starts at window entry 0 (the oldest) and stops at the first entry whose `ready_i` bit is low; younger entries do not retire even if ready.
- R3: At most `W` non-squashed entries retire per cycle; `retire_cnt_o` reports that number (0 to `W`) and `retire_o[i]` is high for each window entry i removed this cycle.
- R4: A ready entry with `squashed_i` set is removed (its `retire_o` bit is high), is counted in `squash_cnt_o` and not in `retire_cnt_o`, and does not use any of the `W` credit.
- R5: An unexecuted entry with `serial_i` or `fence_i` set stops the walk. If no earlier real instruction retired this cycle and `stores_pend_i` is low, `nonspec_req_o` is raised with `nonspec_seq_o` equal to its sequence number; otherwise no request is raised.
- R6: An unexecuted load (`load_i` set, `serial_i` and `fence_i` clear) stops the walk and raises `replay_req_o` with `replay_seq_o` equal to its sequence number. Any other unexecuted entry stalls the walk and raises nothing.
- R7: An executed entry with `fault_i` set stops the walk. It raises `trap_req_o` only under the gating of R5. A trap request sets `trap_pending_o` from the next cycle, and `trap_pending_o` stays set until `trap_done_i` is sampled high.
- R8: In the cycle after any real instruction retired, `pc_o` equals the `npc_i` of the youngest one retired and `npc_o` equals that value plus 4. Otherwise both hold their values.
- R9: `done_valid_o` is high when at least one real instruction retires, and `done_seq_o` then carries the sequence number of the youngest of them.
- R10: `insn_cnt_o` counts the retired real instructions whose `no_count_i` bit (nop or instruction prefetch) is clear.
- R11: `full_cnt_o` increments by one in the cycle after a cycle in which `retire_cnt_o` equals `W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_valid_i | input | 1 | Thread selector has picked a thread this cycle |
| stores_pend_i | input | 1 | Stores are still waiting for writeback |
| trap_done_i | input | 1 | Trap handler has finished; clears the trap-pending state |
| ready_i | input | D | Window entry holds a head ready to commit (entry 0 oldest) |
| squashed_i | input | D | Entry was squashed |
| executed_i | input | D | Entry has executed |
| serial_i | input | D | Entry is non-speculative or a conditional store |
| fence_i | input | D | Entry is a memory or write barrier |
| load_i | input | D | Entry is a load |
| fault_i | input | D | Entry carries a fault |
| no_count_i | input | D | Entry is a nop or an instruction prefetch |
| seq_i | input | D*SEQ_W | Sequence number per entry |
| npc_i | input | D*PC_W | Next-PC per entry |
| retire_o | output | D | Entry removed this cycle |
| retire_cnt_o | output | clog2(W+1) | Real instructions retired this cycle |
| insn_cnt_o | output | clog2(W+1) | Retired instructions excluding nops and prefetches |
| squash_cnt_o | output | clog2(D+1) | Squashed entries removed this cycle |
| done_valid_o | output | 1 | At least one real instruction retired |
| done_seq_o | output | SEQ_W | Sequence number of the youngest retired instruction |
| nonspec_req_o | output | 1 | Request to execute a serialising instruction |
| nonspec_seq_o | output | SEQ_W | Its sequence number |
| replay_req_o | output | 1 | Request to replay an uncached load |
| replay_seq_o | output | SEQ_W | Its sequence number |
| trap_req_o | output | 1 | Trap request for a faulting head |
| trap_pending_o | output | 1 | Trap raised and not yet handled |
| pc_o | output | PC_W | Architectural PC |
| npc_o | output | PC_W | Architectural next-PC |
| full_cnt_o | output | FC_W | Cycles in which the full width retired |

## Verification
The bench targets the places where the walk must stop or skip. A squashed run ahead of real work must still allow four real retirements: a design that charged squashed entries to the credit would retire only two. A serialising or faulting head is tried behind an older retirement, with stores pending, and alone with no stores pending. A design that ignored the slot rule or the store rule would fire a request early, and one that forgot to stop would retire younger entries past it. A serialising head right after a squashed entry must still count as first in the cycle. The bench also checks that the trap-pending state holds retirement off through the cycle that clears it. It checks that PC, next-PC and the full-width counter move only one cycle after the retirements that cause them.

// File: rtl/retire_pkg.sv
package retire_pkg;

  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_NONSPEC = 2'd1,
    REQ_REPLAY  = 2'd2,
    REQ_TRAP    = 2'd3
  } req_e;

  typedef struct packed {
    logic ready;
    logic squashed;
    logic executed;
    logic serial;
    logic fence;
    logic load;
    logic fault;
    logic no_count;
  } head_t;

endpackage

// File: rtl/retire_stage.sv
// One link of the retirement walk: decides the fate of one window entry.
module retire_stage
  import retire_pkg::*;
#(
  parameter int W     = 4,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  head_t            head_i,
  input  logic             stores_pend_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             stop_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             remove_o,
  output logic             commit_o,
  output logic             counted_o,
  output logic             squash_o,
  output req_e             req_o
);

  localparam logic [CNT_W-1:0] CREDIT = CNT_W'(W);

  logic first_slot;
  assign first_slot = (cnt_i == '0) && !stores_pend_i;

  always_comb begin
    stop_o    = stop_i;
    cnt_o     = cnt_i;
    remove_o  = 1'b0;
    commit_o  = 1'b0;
    counted_o = 1'b0;
    squash_o  = 1'b0;
    req_o     = REQ_NONE;
    if (!stop_i) begin
      if (!head_i.ready) begin
        stop_o = 1'b1;
      end else if (head_i.squashed) begin
        remove_o = 1'b1;
        squash_o = 1'b1;
      end else if (cnt_i == CREDIT) begin
        stop_o = 1'b1;
      end else if (!head_i.executed) begin
        stop_o = 1'b1;
        if (head_i.serial || head_i.fence) begin
          if (first_slot) req_o = REQ_NONSPEC;
        end else if (head_i.load) begin
          req_o = REQ_REPLAY;
        end
      end else if (head_i.fault) begin
        stop_o = 1'b1;
        if (first_slot) req_o = REQ_TRAP;
      end else begin
        remove_o  = 1'b1;
        commit_o  = 1'b1;
        counted_o = !head_i.no_count;
        cnt_o     = cnt_i + 1'b1;
      end
    end
  end

endmodule

// File: rtl/retire_track.sv
// Architectural PC, trap-pending state and full-width cycle counter.
module retire_track #(
  parameter int          PC_W     = 32,
  parameter int          FC_W     = 16,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter int          INSN_SZ  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_any_i,
  input  logic [PC_W-1:0] last_npc_i,
  input  logic            full_hit_i,
  input  logic            trap_set_i,
  input  logic            trap_clr_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o,
  output logic [FC_W-1:0] full_cnt_o,
  output logic            trap_pending_o
);

  localparam logic [PC_W-1:0] PC_INIT = PC_W'(RESET_PC);
  localparam logic [PC_W-1:0] STEP    = PC_W'(INSN_SZ);

  logic [PC_W-1:0] pc_q, npc_q;
  logic [FC_W-1:0] full_q;
  logic            trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= PC_INIT;
      npc_q <= PC_INIT + STEP;
    end else if (commit_any_i) begin
      pc_q  <= last_npc_i;
      npc_q <= last_npc_i + STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         full_q <= '0;
    else if (full_hit_i) full_q <= full_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         trap_q <= 1'b0;
    else if (trap_clr_i) trap_q <= 1'b0;
    else if (trap_set_i) trap_q <= 1'b1;
  end

  assign pc_o           = pc_q;
  assign npc_o          = npc_q;
  assign full_cnt_o     = full_q;
  assign trap_pending_o = trap_q;

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import retire_pkg::*;
#(
  parameter int          W        = 4,
  parameter int          D        = 2 * W,
  parameter int          SEQ_W    = 16,
  parameter int          PC_W     = 32,
  parameter int          FC_W     = 16,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sel_valid_i,
  input  logic                     stores_pend_i,
  input  logic                     trap_done_i,
  input  logic [D-1:0]             ready_i,
  input  logic [D-1:0]             squashed_i,
  input  logic [D-1:0]             executed_i,
  input  logic [D-1:0]             serial_i,
  input  logic [D-1:0]             fence_i,
  input  logic [D-1:0]             load_i,
  input  logic [D-1:0]             fault_i,
  input  logic [D-1:0]             no_count_i,
  input  logic [D*SEQ_W-1:0]       seq_i,
  input  logic [D*PC_W-1:0]        npc_i,
  output logic [D-1:0]             retire_o,
  output logic [$clog2(W+1)-1:0]   retire_cnt_o,
  output logic [$clog2(W+1)-1:0]   insn_cnt_o,
  output logic [$clog2(D+1)-1:0]   squash_cnt_o,
  output logic                     done_valid_o,
  output logic [SEQ_W-1:0]         done_seq_o,
  output logic                     nonspec_req_o,
  output logic [SEQ_W-1:0]         nonspec_seq_o,
  output logic                     replay_req_o,
  output logic [SEQ_W-1:0]         replay_seq_o,
  output logic                     trap_req_o,
  output logic                     trap_pending_o,
  output logic [PC_W-1:0]          pc_o,
  output logic [PC_W-1:0]          npc_o,
  output logic [FC_W-1:0]          full_cnt_o
);

  localparam int CNT_W = $clog2(W + 1);
  localparam int SQ_W  = $clog2(D + 1);

  logic             stop_c [D+1];
  logic [CNT_W-1:0] cnt_c  [D+1];
  logic [D-1:0]     commit_v, counted_v, squash_v;
  req_e             req_v  [D];
  logic             trap_pend;

  assign stop_c[0] = !sel_valid_i || trap_pend;
  assign cnt_c[0]  = '0;

  for (genvar i = 0; i < D; i++) begin : g_walk
    head_t h;
    assign h = '{ready:    ready_i[i],    squashed: squashed_i[i],
                 executed: executed_i[i], serial:   serial_i[i],
                 fence:    fence_i[i],    load:     load_i[i],
                 fault:    fault_i[i],    no_count: no_count_i[i]};

    retire_stage #(.W(W), .CNT_W(CNT_W)) u_stage (
      .head_i       (h),
      .stores_pend_i(stores_pend_i),
      .stop_i       (stop_c[i]),
      .cnt_i        (cnt_c[i]),
      .stop_o       (stop_c[i+1]),
      .cnt_o        (cnt_c[i+1]),
      .remove_o     (retire_o[i]),
      .commit_o     (commit_v[i]),
      .counted_o    (counted_v[i]),
      .squash_o     (squash_v[i]),
      .req_o        (req_v[i])
    );
  end

  logic [PC_W-1:0] last_npc;
  logic [CNT_W-1:0] insn_sum;
  logic [SQ_W-1:0]  sq_sum;

  always_comb begin
    last_npc      = '0;
    done_seq_o    = '0;
    insn_sum      = '0;
    sq_sum        = '0;
    nonspec_req_o = 1'b0;
    nonspec_seq_o = '0;
    replay_req_o  = 1'b0;
    replay_seq_o  = '0;
    trap_req_o    = 1'b0;
    for (int i = 0; i < D; i++) begin
      insn_sum = insn_sum + CNT_W'(counted_v[i]);
      sq_sum   = sq_sum + SQ_W'(squash_v[i]);
      if (commit_v[i]) begin
        last_npc   = npc_i[i*PC_W +: PC_W];
        done_seq_o = seq_i[i*SEQ_W +: SEQ_W];
      end
      unique case (req_v[i])
        REQ_NONSPEC: begin
          nonspec_req_o = 1'b1;
          nonspec_seq_o = seq_i[i*SEQ_W +: SEQ_W];
        end
        REQ_REPLAY: begin
          replay_req_o = 1'b1;
          replay_seq_o = seq_i[i*SEQ_W +: SEQ_W];
        end
        REQ_TRAP: trap_req_o = 1'b1;
        default: ;
      endcase
    end
  end

  assign retire_cnt_o = cnt_c[D];
  assign insn_cnt_o   = insn_sum;
  assign squash_cnt_o = sq_sum;
  assign done_valid_o = |commit_v;

  retire_track #(
    .PC_W(PC_W), .FC_W(FC_W), .RESET_PC(RESET_PC), .INSN_SZ(4)
  ) u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_any_i  (|commit_v),
    .last_npc_i    (last_npc),
    .full_hit_i    (cnt_c[D] == CNT_W'(W)),
    .trap_set_i    (trap_req_o),
    .trap_clr_i    (trap_done_i),
    .pc_o          (pc_o),
    .npc_o         (npc_o),
    .full_cnt_o    (full_cnt_o),
    .trap_pending_o(trap_pend)
  );

  assign trap_pending_o = trap_pend;

endmodule

// File: rtl/retire_ctrl_chk.sv
module retire_ctrl_chk #(
  parameter int W     = 4,
  parameter int D     = 2 * W,
  parameter int PC_W  = 32,
  parameter int FC_W  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sel_valid_i,
  input logic                   stores_pend_i,
  input logic                   trap_done_i,
  input logic [D-1:0]           retire_o,
  input logic [$clog2(W+1)-1:0] retire_cnt_o,
  input logic [$clog2(D+1)-1:0] squash_cnt_o,
  input logic                   nonspec_req_o,
  input logic                   replay_req_o,
  input logic                   trap_req_o,
  input logic                   trap_pending_o,
  input logic [PC_W-1:0]        pc_o,
  input logic [FC_W-1:0]        full_cnt_o
);

  // R3
  width_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(retire_cnt_o) <= W);

  // R4
  squash_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(retire_cnt_o) + int'(squash_cnt_o) == $countones(retire_o));

  // R2
  no_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_i |-> retire_o == '0);

  // R5
  nonspec_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonspec_req_o |-> (!stores_pend_i && retire_cnt_o == '0));

  // R7
  trap_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> (!stores_pend_i && retire_cnt_o == '0));

  // R6
  one_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nonspec_req_o, replay_req_o, trap_req_o}));

  // R7
  trap_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o && !trap_done_i) |=> trap_pending_o);

  // R7
  trap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_pending_o |-> (retire_o == '0 && !trap_req_o));

  // R8
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_cnt_o == '0) |=> $stable(pc_o));

  // R11
  full_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(retire_cnt_o) == W) |=> full_cnt_o == $past(full_cnt_o) + 1'b1);

endmodule

bind retire_ctrl retire_ctrl_chk #(.W(W), .D(D), .PC_W(PC_W), .FC_W(FC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_valid_i   (sel_valid_i),
  .stores_pend_i (stores_pend_i),
  .trap_done_i   (trap_done_i),
  .retire_o      (retire_o),
  .retire_cnt_o  (retire_cnt_o),
  .squash_cnt_o  (squash_cnt_o),
  .nonspec_req_o (nonspec_req_o),
  .replay_req_o  (replay_req_o),
  .trap_req_o    (trap_req_o),
  .trap_pending_o(trap_pending_o),
  .pc_o          (pc_o),
  .full_cnt_o    (full_cnt_o)
);

// File: tb/retire_ctrl_bench.sv
module retire_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int D = 8;
  localparam int SEQ_W = 16;
  localparam int PC_W = 32;
  localparam int FC_W = 16;
  localparam int CW = $clog2(W + 1);
  localparam int SW = $clog2(D + 1);
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic sel_v = 1'b0, st_p = 1'b0, t_done = 1'b0;
  logic [D-1:0] rdy = '0, sq = '0, ex = '0, ser = '0, fen = '0, ld = '0, flt = '0, nc = '0;
  logic [D*SEQ_W-1:0] seqv;
  logic [D*PC_W-1:0]  npcv;

  logic [D-1:0] ret;
  logic [CW-1:0] rcnt, icnt;
  logic [SW-1:0] scnt;
  logic dv, nsr, rpr, tr, tp;
  logic [SEQ_W-1:0] dseq, nss, rps;
  logic [PC_W-1:0] pc, npc;
  logic [FC_W-1:0] fcnt;

  retire_ctrl #(.W(W), .D(D), .SEQ_W(SEQ_W), .PC_W(PC_W), .FC_W(FC_W), .RESET_PC(RPC))
  u_retire_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_valid_i(sel_v), .stores_pend_i(st_p),
    .trap_done_i(t_done), .ready_i(rdy), .squashed_i(sq), .executed_i(ex),
    .serial_i(ser), .fence_i(fen), .load_i(ld), .fault_i(flt), .no_count_i(nc),
    .seq_i(seqv), .npc_i(npcv), .retire_o(ret), .retire_cnt_o(rcnt),
    .insn_cnt_o(icnt), .squash_cnt_o(scnt), .done_valid_o(dv), .done_seq_o(dseq),
    .nonspec_req_o(nsr), .nonspec_seq_o(nss), .replay_req_o(rpr), .replay_seq_o(rps),
    .trap_req_o(tr), .trap_pending_o(tp), .pc_o(pc), .npc_o(npc), .full_cnt_o(fcnt)
  );

  typedef struct {
    logic [D-1:0] mask;
    int cnt, ins, sqc, rk, rs;
    logic dvld;
    int dseq, pc, full, tp;
    string tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // next-cycle stimulus, copied onto the pins at the falling edge
  logic n_sel, n_st, n_td;
  logic [D-1:0] n_rdy, n_sq, n_ex, n_ser, n_fen, n_ld, n_flt, n_nc;
  int pc_m = int'(RPC), full_m = 0, tp_m = 0;

  function automatic int seq_of(int i); return 16'h0100 + i; endfunction
  function automatic int npc_of(int i); return 32'h2000 + 4 * (i + 1); endfunction

  task automatic chk(string r, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic clear_next();
    n_sel = 1'b1; n_st = 1'b0; n_td = 1'b0;
    n_rdy = '1; n_sq = '0; n_ex = '1; n_ser = '0; n_fen = '0; n_ld = '0; n_flt = '0; n_nc = '0;
  endtask

  task automatic step(input logic [D-1:0] m, input int c, input int ins, input int sqc,
                      input int rk, input int rs, input string tag);
    item_t it;
    int last;
    @(negedge clk);
    sel_v = n_sel; st_p = n_st; t_done = n_td;
    rdy = n_rdy; sq = n_sq; ex = n_ex; ser = n_ser; fen = n_fen; ld = n_ld; flt = n_flt; nc = n_nc;
    last = -1;
    for (int i = 0; i < D; i++) if (m[i] && !n_sq[i]) last = i;
    it.mask = m; it.cnt = c; it.ins = ins; it.sqc = sqc; it.rk = rk; it.rs = rs;
    it.dvld = (last >= 0); it.dseq = (last >= 0) ? seq_of(last) : 0;
    it.pc = pc_m; it.full = full_m; it.tp = tp_m; it.tag = tag;
    q.push_back(it);
    if (last >= 0) pc_m = npc_of(last);
    if (c == W) full_m++;
    if (n_td) tp_m = 0;
    else if (rk == 3) tp_m = 1;
    clear_next();
  endtask

  // monitor: pops one expected item per cycle, compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD / 4);
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        chk({e.tag, " retire mask"}, int'(ret), int'(e.mask));
        chk({e.tag, " retire count R3"}, int'(rcnt), e.cnt);
        chk({e.tag, " insn count R10"}, int'(icnt), e.ins);
        chk({e.tag, " squash count R4"}, int'(scnt), e.sqc);
        chk({e.tag, " request kind"}, int'({tr, rpr, nsr}),
            (e.rk == 0) ? 0 : (1 << (e.rk - 1)));
        if (e.rk == 1) chk({e.tag, " nonspec seq R5"}, int'(nss), e.rs);
        if (e.rk == 2) chk({e.tag, " replay seq R6"}, int'(rps), e.rs);
        chk({e.tag, " done valid R9"}, int'(dv), int'(e.dvld));
        if (e.dvld) chk({e.tag, " done seq R9"}, int'(dseq), e.dseq);
        chk({e.tag, " pc R8"}, int'(pc), e.pc);
        chk({e.tag, " npc R8"}, int'(npc), e.pc + 4);
        chk({e.tag, " full count R11"}, int'(fcnt), e.full);
        chk({e.tag, " trap pending R7"}, int'(tp), e.tp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      seqv[i*SEQ_W +: SEQ_W] = SEQ_W'(seq_of(i));
      npcv[i*PC_W +: PC_W]   = PC_W'(npc_of(i));
    end
    clear_next();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: reset values, nothing retires without a selected thread
    n_sel = 1'b0;
    step(8'h00, 0, 0, 0, 0, 0, "R1 R2 reset/idle");
    // R3 R9: full window ready, only W retire
    step(8'h0F, 4, 4, 0, 0, 0, "R3 R9 width");
    // R4 R8 R11: squashed heads ride free
    n_sq = 8'h03;
    step(8'h3F, 4, 4, 2, 0, 0, "R4 squash free");
    // R2: stop at first not-ready entry
    n_rdy = 8'h0B;
    step(8'h03, 2, 2, 0, 0, 0, "R2 not ready stop");
    // R10: nop not counted
    n_nc = 8'h02;
    step(8'h0F, 4, 3, 0, 0, 0, "R10 nop");
    // R5: serial entry behind a retirement waits
    n_ex = 8'hFD; n_ser = 8'h02;
    step(8'h01, 1, 1, 0, 0, 0, "R5 not first slot");
    // R5: serial at head, stores pending
    n_ex = 8'hFE; n_ser = 8'h01; n_st = 1'b1;
    step(8'h00, 0, 0, 0, 0, 0, "R5 stores pending");
    // R5: serial at head, clear
    n_ex = 8'hFE; n_ser = 8'h01;
    step(8'h00, 0, 0, 0, 1, seq_of(0), "R5 issue");
    // R4 R5: barrier right after a squashed entry is still first
    n_sq = 8'h01; n_ex = 8'hFD; n_fen = 8'h02;
    step(8'h01, 0, 0, 1, 1, seq_of(1), "R4 R5 fence after squash");
    // R6: unexecuted load replay
    n_ex = 8'hFD; n_ld = 8'h02;
    step(8'h01, 1, 1, 0, 2, seq_of(1), "R6 replay");
    // R6: unexecuted entry of no class stalls silently
    n_ex = 8'hFB;
    step(8'h03, 2, 2, 0, 0, 0, "R6 plain stall");
    // R7: fault not in first slot
    n_flt = 8'h02;
    step(8'h01, 1, 1, 0, 0, 0, "R7 fault not first");
    // R7: fault with stores pending
    n_flt = 8'h01; n_st = 1'b1;
    step(8'h00, 0, 0, 0, 0, 0, "R7 fault stores");
    // R7: trap raised
    n_flt = 8'h01;
    step(8'h00, 0, 0, 0, 3, 0, "R7 trap");
    // R7: pending blocks retirement
    step(8'h00, 0, 0, 0, 0, 0, "R7 pending hold");
    n_td = 1'b1;
    step(8'h00, 0, 0, 0, 0, 0, "R7 pending clear cycle");
    // R7 R3: retirement resumes
    step(8'h0F, 4, 4, 0, 0, 0, "R7 resume");
    // R2: selector idle
    n_sel = 1'b0;
    step(8'h00, 0, 0, 0, 0, 0, "R2 no select");
    n_sel = 1'b0;
    step(8'h00, 0, 0, 0, 0, 0, "R8 R11 final state");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule